// File: doc/BRIEF.md
# BCD calendar time counter

This block holds the time of day and the calendar date as packed BCD fields: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle pulse on `tick_1hz`, supplied by an external prescaler, advances the chain by one second. Each field rolls over into the next. Day of month follows the length of the current month, and February has a leap day when the BCD year is a multiple of four.

Software reaches the block through a byte-wide register port. It stops the chain and loads the fields, then starts the chain again. A self-clearing clear bit puts the fields back to their initial date. A 12-hour mode counts 1 to 12 and keeps the afternoon marker in bit 6 of the hours field.

Every second that the chain advances also raises a sticky carry flag. Software clears this flag before it reads the fields and checks it afterwards. If the flag is set again, a second boundary fell inside the read and the fields must be read again. When the flag is set and its enable bit is set, an interrupt output is raised.

Top module: `bcd_calendar`

## Requirements
- R1: On each accepted tick, seconds count 00 to 59 in BCD. From 59 they return to 00 and minutes advance. Minutes follow the same rule and advance the hours. A low digit of 9 carries into the high digit.
- R2: With the 24-hour bit set, hours count 00 to 23 and keep bit 6 at 0. Leaving 23:59:59 gives 00:00:00 and advances the date.
- R3: With the 24-hour bit clear, hours run 12, 01 to 11, and bit 6 marks the afternoon. 11 rolls to 12 and toggles bit 6. 12 rolls to 01 and keeps bit 6. Going from 11 with bit 6 set to 12 with bit 6 clear advances the date.
- R4: Day of month rolls to 01 after the last day of the month: 31, or 30 for months 04, 06, 09 and 11, or February's 28. February has 29 days when the BCD year is divisible by four, and this includes 00.
- R5: Day of week counts 0 to 6 and wraps to 0 with each date advance. Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R6: Control register (address 8): bit 0 is start, bit 1 is clear, bit 2 is 24-hour. The fields advance only on a tick while start is 1, and bit 0 reads back the run state.
- R7: The field registers are at addresses 0 to 6: seconds, minutes, hours, day of week, day of month, month, year. A write to these addresses takes effect only while stopped and is ignored while running.
- R8: Writing 1 to the clear bit makes the bit read 1 for one cycle. The bit then reads 0 by itself, and the fields become 00:00:00, weekday 0, day 01, month 01, year 00. The hours field becomes 12 in 12-hour mode. The same values, with 24-hour mode set and stopped, apply after `rst_n`.
- R9: Status register (address 9), bit 1: set by every accepted tick, cleared by writing 0 to that bit. Writing 1 has no effect, and a tick in the same cycle as a clear wins.
- R10: Interrupt-enable register (address 10), bit 1 enables the carry interrupt. `carry_irq` is high while both the flag and the enable are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| carry_irq | output | 1 | Carry interrupt request |

## Verification
The hardest cases to reach are the rare rollovers, such as end of year, leap February in year 00 and the 11 PM to 12 AM change in 12-hour mode. Counting up to them from reset would take millions of ticks. The bench therefore stops the chain, loads the fields one second before each boundary, runs the chain for exactly one tick and reads back all seven fields. The clear bit, which reads 1 for a single cycle, is sampled in the cycle right after its write.

// File: rtl/bcd_calendar.sv
module bcd_calendar (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       carry_irq
);
  logic [6:0] sec, min, hr, hr_n;
  logic [2:0] wday;
  logic [5:0] mday;
  logic [4:0] mon;
  logic [7:0] yr;
  logic       run, clr_busy, h24, carry, carry_en, day_c;
  logic [7:0] sec_i, min_i, hr_i, md_i, mo_i, yr_i, last_day;
  logic       adv, sec_w, min_w, md_w, mo_w, leap;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  assign adv   = tick_1hz & run & ~clr_busy;
  assign sec_w = (sec == 7'h59);
  assign min_w = (min == 7'h59);
  assign sec_i = bcd_inc({1'b0, sec});
  assign min_i = bcd_inc({1'b0, min});
  assign hr_i  = bcd_inc({2'b0, hr[5:0]});
  assign md_i  = bcd_inc({2'b0, mday});
  assign mo_i  = bcd_inc({3'b0, mon});
  assign yr_i  = bcd_inc(yr);
  assign leap  = (((yr[4] ? yr[3:0] + 4'd2 : yr[3:0]) & 4'd3) == 4'd0);

  always_comb begin
    case (mon)
      5'h02:                      last_day = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
  assign md_w = ({2'b0, mday} == last_day);
  assign mo_w = (mon == 5'h12);

  always_comb begin
    day_c = 1'b0;
    hr_n  = {hr[6], hr_i[5:0]};
    if (h24) begin
      if (hr[5:0] == 6'h23) begin
        hr_n  = 7'h00;
        day_c = 1'b1;
      end else begin
        hr_n  = {1'b0, hr_i[5:0]};
      end
    end else if (hr[5:0] == 6'h12) begin
      hr_n = {hr[6], 6'h01};
    end else if (hr[5:0] == 6'h11) begin
      hr_n  = {~hr[6], 6'h12};
      day_c = hr[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= '0; min <= '0; hr <= '0; wday <= '0;
      mday <= 6'h01; mon <= 5'h01; yr <= '0;
      run <= 1'b0; clr_busy <= 1'b0; h24 <= 1'b1;
      carry <= 1'b0; carry_en <= 1'b0;
    end else begin
      if (clr_busy) begin
        sec <= '0; min <= '0; wday <= '0;
        hr <= h24 ? 7'h00 : 7'h12;
        mday <= 6'h01; mon <= 5'h01; yr <= '0;
        clr_busy <= 1'b0;
      end else if (adv) begin
        sec <= sec_w ? 7'h00 : sec_i[6:0];
        if (sec_w) min <= min_w ? 7'h00 : min_i[6:0];
        if (sec_w && min_w) hr <= hr_n;
        if (sec_w && min_w && day_c) begin
          wday <= (wday == 3'd6) ? 3'd0 : wday + 3'd1;
          mday <= md_w ? 6'h01 : md_i[5:0];
          if (md_w) begin
            mon <= mo_w ? 5'h01 : mo_i[4:0];
            if (mo_w) yr <= (yr == 8'h99) ? 8'h00 : yr_i;
          end
        end
      end else if (wr_en && !run) begin
        case (addr)
          4'd0: sec  <= wdata[6:0];
          4'd1: min  <= wdata[6:0];
          4'd2: hr   <= h24 ? {1'b0, wdata[5:0]} : wdata[6:0];
          4'd3: wday <= wdata[2:0];
          4'd4: mday <= wdata[5:0];
          4'd5: mon  <= wdata[4:0];
          4'd6: yr   <= wdata;
          default: ;
        endcase
      end
      if (wr_en && addr == 4'd8) begin
        run <= wdata[0];
        h24 <= wdata[2];
        if (wdata[1]) clr_busy <= 1'b1;
      end
      if (adv) carry <= 1'b1;
      else if (wr_en && addr == 4'd9 && !wdata[1]) carry <= 1'b0;
      if (wr_en && addr == 4'd10) carry_en <= wdata[1];
    end
  end

  always_comb begin
    case (addr)
      4'd0:    rdata = {1'b0, sec};
      4'd1:    rdata = {1'b0, min};
      4'd2:    rdata = {1'b0, hr};
      4'd3:    rdata = {5'b0, wday};
      4'd4:    rdata = {2'b0, mday};
      4'd5:    rdata = {3'b0, mon};
      4'd6:    rdata = yr;
      4'd8:    rdata = {5'b0, h24, clr_busy, run};
      4'd9:    rdata = {6'b0, carry, 1'b0};
      4'd10:   rdata = {6'b0, carry_en, 1'b0};
      default: rdata = 8'h00;
    endcase
  end

  assign carry_irq = carry & carry_en;

  assert_sec_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && sec == 7'h59) |=> (sec == 7'h00 && min != $past(min)));
  assert_hour_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && h24 && hr == 7'h23 && min == 7'h59 && sec == 7'h59) |=> (hr == 7'h00));
  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en && !clr_busy) |=> $stable({sec, min, hr, wday, mday, mon, yr}));
  assert_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en && addr < 4'd7 && !tick_1hz && !clr_busy)
      |=> $stable({sec, min, hr, wday, mday, mon, yr}));
  assert_clr_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_busy && !(wr_en && addr == 4'd8 && wdata[1]))
      |=> (!clr_busy && sec == 7'h00 && mday == 6'h01 && mon == 5'h01 && yr == 8'h00));
  assert_carry_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> carry);
endmodule

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic carry_irq;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcd_calendar u_bcd_calendar (.clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .carry_irq(carry_irq));

  // {mode(1=24h), sec,min,hr,wday,mday,mon,yr, expected same seven fields}
  localparam int NV = 16;
  localparam logic [119:0] VEC [NV] = '{
    {8'h01, 56'h00_00_00_01_15_03_24, 56'h01_00_00_01_15_03_24},  // R1
    {8'h01, 56'h59_34_12_02_15_03_24, 56'h00_35_12_02_15_03_24},  // R1
    {8'h01, 56'h59_59_09_02_15_03_24, 56'h00_00_10_02_15_03_24},  // R1 R2
    {8'h01, 56'h59_59_23_06_31_12_99, 56'h00_00_00_00_01_01_00},  // R2 R5
    {8'h01, 56'h59_59_23_02_28_02_24, 56'h00_00_00_03_29_02_24},  // R4
    {8'h01, 56'h59_59_23_02_28_02_23, 56'h00_00_00_03_01_03_23},  // R4
    {8'h01, 56'h59_59_23_04_29_02_00, 56'h00_00_00_05_01_03_00},  // R4
    {8'h01, 56'h59_59_23_04_30_04_21, 56'h00_00_00_05_01_05_21},  // R4
    {8'h01, 56'h59_59_23_01_31_01_21, 56'h00_00_00_02_01_02_21},  // R4
    {8'h01, 56'h59_59_23_03_30_09_21, 56'h00_00_00_04_01_10_21},  // R4 R5
    {8'h01, 56'h59_59_23_03_28_02_96, 56'h00_00_00_04_29_02_96},  // R4
    {8'h01, 56'h59_59_23_03_28_02_98, 56'h00_00_00_04_01_03_98},  // R4
    {8'h00, 56'h59_59_11_01_10_05_22, 56'h00_00_52_01_10_05_22},  // R3
    {8'h00, 56'h59_59_51_01_10_05_22, 56'h00_00_12_02_11_05_22},  // R3
    {8'h00, 56'h59_59_52_01_10_05_22, 56'h00_00_41_01_10_05_22},  // R3
    {8'h00, 56'h59_59_12_01_10_05_22, 56'h00_00_01_01_10_05_22}   // R3
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rd_all(output logic [55:0] t);
    logic [7:0] b;
    for (int i = 0; i < 7; i++) begin
      rd(i[3:0], b);
      t[55 - 8*i -: 8] = b;
    end
  endtask

  task automatic load(input logic h, input logic [55:0] t);
    wr(4'd8, {5'b0, h, 2'b00});
    for (int i = 0; i < 7; i++) wr(i[3:0], t[55 - 8*i -: 8]);
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [55:0] t;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd_all(t); chk("R8 reset fields", {8'h0, t}, {8'h0, 56'h00_00_00_00_01_01_00});
    rd(4'd8, b); chk("R8 reset control", {56'h0, b}, 64'h04);
    rd(4'd9, b); chk("R9 reset status", {56'h0, b}, 64'h00);
    chk("R10 reset irq", {63'h0, carry_irq}, 64'h0);

    for (int v = 0; v < NV; v++) begin
      load(VEC[v][112], VEC[v][111:56]);
      wr(4'd8, {5'b0, VEC[v][112], 2'b01});
      tick();
      wr(4'd8, {5'b0, VEC[v][112], 2'b00});
      rd_all(t);
      chk($sformatf("vector %0d", v), {8'h0, t}, {8'h0, VEC[v][55:0]});
    end

    load(1'b1, 56'h10_20_05_03_12_06_30);
    tick();
    rd_all(t); chk("R6 tick while stopped", {8'h0, t}, {8'h0, 56'h10_20_05_03_12_06_30});
    wr(4'd8, 8'h05);
    rd(4'd8, b); chk("R6 start readback", {56'h0, b}, 64'h05);
    wr(4'd0, 8'h45);
    rd(4'd0, b); chk("R7 write while running", {56'h0, b}, 64'h10);
    tick();
    rd(4'd0, b); chk("R6 tick while running", {56'h0, b}, 64'h11);

    wr(4'd9, 8'h00);
    rd(4'd9, b); chk("R9 clear flag", {56'h0, b}, 64'h00);
    tick();
    rd(4'd9, b); chk("R9 flag on tick", {56'h0, b}, 64'h02);
    chk("R10 irq masked", {63'h0, carry_irq}, 64'h0);
    wr(4'd9, 8'h02);
    rd(4'd9, b); chk("R9 write one keeps", {56'h0, b}, 64'h02);
    wr(4'd10, 8'h02);
    rd(4'd10, b); chk("R10 enable readback", {56'h0, b}, 64'h02);
    chk("R10 irq raised", {63'h0, carry_irq}, 64'h1);
    wr(4'd9, 8'h00);
    chk("R10 irq drops", {63'h0, carry_irq}, 64'h0);
    wr(4'd9, 8'h02);
    rd(4'd9, b); chk("R9 write one no set", {56'h0, b}, 64'h00);

    wr(4'd8, 8'h06);
    rd(4'd8, b); chk("R8 clear bit visible", {56'h0, b}, 64'h06);
    @(negedge clk);
    rd(4'd8, b); chk("R8 clear bit self-clears", {56'h0, b}, 64'h04);
    rd_all(t); chk("R8 fields cleared", {8'h0, t}, {8'h0, 56'h00_00_00_00_01_01_00});
    wr(4'd8, 8'h02);
    @(negedge clk);
    rd(4'd2, b); chk("R8 clear in 12-hour mode", {56'h0, b}, 64'h12);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule